// File: doc/BRIEF.md
# Streaming Memory Read Sequencer with CRC-16 Trailers

This block turns a three-byte read request into a stream of memory bytes with 16-bit CRC trailers. A host sends a command byte and a 16-bit start address, low byte first, on a byte-wide ready/valid input. The block then fetches bytes one at a time through a read port into an external memory model. It hands each byte to the host on a byte-wide ready/valid output, and it places a CRC-16 trailer at the end of each defined segment.

Two commands are served. The main-field read (0xF0) runs from the start address to the highest main address and then gives one trailer. The status-field read (0xAA) gives a trailer at the end of every 8-byte status page. Each trailer after the first restarts its CRC and covers only that page's data. Once a stream is exhausted the output reads as all ones. A synchronous abort input drops any read in progress and re-arms the header capture. Bit-level serial timing and device selection belong to other blocks.

Top module: `memread_crc_seq`

## Requirements
- R1: After reset or abort, `in_ready` is 1 and `out_valid` is 0. The first three bytes accepted are taken as command, address low byte and address high byte. `in_ready` stays 0 while a stream is active.
- R2: Command 0xF0 returns main-field bytes in ascending order, from the start address through address 2^MAIN_AW-1, one byte per output handshake.
- R3: After the last main byte the block sends a trailer of two bytes: the bitwise inverse of the CRC, low byte first. The CRC uses polynomial x^16+x^15+x^2+1 in reflected form (0xA001), starts at 0 and takes the bits of each byte least significant bit first. It covers the command, the address low byte, the address high byte and every data byte sent.
- R4: After the last trailer of a stream, `out_valid` stays 1 and every byte taken is 0xFF until an abort.
- R5: A one-cycle `abort_i` pulse ends the read with no trailer. `out_valid` falls on the next cycle and stays low, and a new header is then accepted normally.
- R6: Command 0xAA returns status bytes from the start address through the end of its 8-byte page, an address with bits [2:0] = 111. A trailer follows, made as in R3 over the command, both address bytes and those data bytes.
- R7: After a status trailer, the stream goes on with the next page. The CRC is cleared first and covers only that page's 8 data bytes. The page ending at address 0x1FF is the last one, and R4 follows it.
- R8: Status addresses 0x060 through 0x0FF read as 0xFF without a memory access. These bytes still enter the CRC.
- R9: A status start address above 0x1FF gives the all-ones output at once. A main start address at or above 2^MAIN_AW gives the trailer at once, over the three header bytes only. Any command other than 0xF0 or 0xAA gives the all-ones output.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_data` holds its value and `out_valid` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| abort_i | input | 1 | Synchronous abort of the current read |
| in_valid | input | 1 | Header byte present |
| in_data | input | 8 | Header byte |
| in_ready | output | 1 | Header byte accepted when high with in_valid |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Output byte (data, trailer or 0xFF) |
| out_ready | input | 1 | Host takes the output byte |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_field | output | 1 | 0 = main field, 1 = status field |
| mem_rd_addr | output | 16 | Memory byte address |
| mem_rd_data | input | 8 | Read data, valid one cycle after the strobe |

## Verification
The hardest point to reach is the handoff between status pages. The CRC must be cleared exactly between the second trailer byte of one page and the first data byte of the next. Only a stream that crosses a page boundary shows this. The stimulus starts status reads a few bytes before a page end, once near 0x1FF so that the final-page cutoff follows, and once at 0x05E so that the next page lies wholly in the unimplemented gap. Main-field reads run with a reduced address width, so that the full run to the last byte and its trailer fits in a short bench.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;

  localparam logic [7:0] CMD_MAIN = 8'hF0;
  localparam logic [7:0] CMD_STAT = 8'hAA;
  localparam logic [15:0] CRC_POLY_REFL = 16'hA001;

  typedef enum logic [2:0] {
    S_HDR,
    S_DISP,
    S_FETCH,
    S_WAIT,
    S_SEND,
    S_CRC_LO,
    S_CRC_HI,
    S_ONES
  } seq_state_t;

  // One byte into the reflected CRC-16, least significant bit first
  function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic        fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[0] ^ d[i];
      r  = r >> 1;
      if (fb) r = r ^ CRC_POLY_REFL;
    end
    return r;
  endfunction

endpackage

// File: rtl/rdseq_hdr.sv
module rdseq_hdr #(
  parameter int HDR_BYTES = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       enable,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       hdr_take,
  output logic       hdr_last,
  output logic [7:0] cmd_q,
  output logic [7:0] addr_lo_q
);
  localparam int CW = $clog2(HDR_BYTES);

  logic [CW-1:0] cnt_q;

  assign hdr_take = in_valid && enable;
  assign hdr_last = hdr_take && (cnt_q == CW'(HDR_BYTES - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q     <= '0;
      cmd_q     <= 8'h00;
      addr_lo_q <= 8'h00;
    end else if (hdr_take) begin
      cnt_q <= hdr_last ? '0 : cnt_q + 1'b1;
      if (cnt_q == CW'(0)) cmd_q     <= in_data;
      if (cnt_q == CW'(1)) addr_lo_q <= in_data;
    end
  end

  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(HDR_BYTES - 1));

endmodule

// File: rtl/rdseq_crc16.sv
module rdseq_crc16 (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        feed,
  input  logic [7:0]  din,
  output logic [15:0] crc_q
);
  import rdseq_pkg::*;

  always_ff @(posedge clk) begin
    if (rst || clr)  crc_q <= 16'h0000;
    else if (feed)   crc_q <= crc16_byte(crc_q, din);
  end

endmodule

// File: rtl/rdseq_stat_map.sv
module rdseq_stat_map #(
  parameter logic [15:0] STAT_LAST = 16'h01FF,
  parameter logic [15:0] GAP_LO    = 16'h0060,
  parameter logic [15:0] GAP_HI    = 16'h00FF,
  parameter int          PAGE_AW   = 3
) (
  input  logic [15:0] addr,
  output logic        in_gap,
  output logic        page_end,
  output logic        last_end,
  output logic        beyond
);
  assign in_gap   = (addr >= GAP_LO) && (addr <= GAP_HI);
  assign page_end = (addr[PAGE_AW-1:0] == '1);
  assign last_end = (addr == STAT_LAST);
  assign beyond   = (addr > STAT_LAST);
endmodule

// File: rtl/memread_crc_seq.sv
module memread_crc_seq #(
  parameter int          MAIN_AW   = 16,
  parameter logic [15:0] STAT_LAST = 16'h01FF,
  parameter logic [15:0] GAP_LO    = 16'h0060,
  parameter logic [15:0] GAP_HI    = 16'h00FF,
  parameter int          PAGE_AW   = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        abort_i,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  output logic        in_ready,
  output logic        out_valid,
  output logic [7:0]  out_data,
  input  logic        out_ready,
  output logic        mem_rd_en,
  output logic        mem_rd_field,
  output logic [15:0] mem_rd_addr,
  input  logic [7:0]  mem_rd_data
);
  import rdseq_pkg::*;

  localparam int HDR_BYTES = 3;

  seq_state_t  state_q;
  logic [15:0] addr_q;
  logic        is_stat_q;
  logic        ff_q;
  logic        out_valid_q;
  logic [7:0]  out_data_q;

  logic        hdr_take, hdr_last;
  logic [7:0]  cmd_q, addr_lo_q;
  logic [15:0] crc_q;
  logic        crc_clr, crc_feed;
  logic [7:0]  crc_din;
  logic        in_gap, page_end, last_end, beyond;
  logic        take_out, main_last, main_oob, seg_end;
  logic [7:0]  fetched;

  assign in_ready  = (state_q == S_HDR);
  assign take_out  = out_valid_q && out_ready;
  assign main_last = (addr_q[MAIN_AW-1:0] == '1);
  assign main_oob  = ((addr_q >> MAIN_AW) != '0);
  assign seg_end   = is_stat_q ? page_end : main_last;
  assign fetched   = ff_q ? 8'hFF : mem_rd_data;

  rdseq_hdr #(.HDR_BYTES(HDR_BYTES)) u_hdr (
    .clk      (clk),
    .rst      (rst),
    .clear    (abort_i),
    .enable   (in_ready),
    .in_valid (in_valid),
    .in_data  (in_data),
    .hdr_take (hdr_take),
    .hdr_last (hdr_last),
    .cmd_q    (cmd_q),
    .addr_lo_q(addr_lo_q)
  );

  assign crc_feed = hdr_take || (state_q == S_WAIT);
  assign crc_din  = hdr_take ? in_data : fetched;
  assign crc_clr  = abort_i ||
                    (state_q == S_CRC_HI && take_out && is_stat_q && !last_end);

  rdseq_crc16 u_crc (
    .clk  (clk),
    .rst  (rst),
    .clr  (crc_clr),
    .feed (crc_feed),
    .din  (crc_din),
    .crc_q(crc_q)
  );

  rdseq_stat_map #(
    .STAT_LAST(STAT_LAST),
    .GAP_LO   (GAP_LO),
    .GAP_HI   (GAP_HI),
    .PAGE_AW  (PAGE_AW)
  ) u_map (
    .addr    (addr_q),
    .in_gap  (in_gap),
    .page_end(page_end),
    .last_end(last_end),
    .beyond  (beyond)
  );

  always_ff @(posedge clk) begin
    if (rst || abort_i) begin
      state_q     <= S_HDR;
      addr_q      <= 16'h0000;
      is_stat_q   <= 1'b0;
      ff_q        <= 1'b0;
      out_valid_q <= 1'b0;
      out_data_q  <= 8'hFF;
    end else begin
      case (state_q)
        S_HDR: begin
          if (hdr_last) begin
            addr_q  <= {in_data, addr_lo_q};
            state_q <= S_DISP;
          end
        end
        S_DISP: begin
          if (cmd_q == CMD_MAIN) begin
            is_stat_q <= 1'b0;
            if (main_oob) begin
              out_data_q  <= ~crc_q[7:0];
              out_valid_q <= 1'b1;
              state_q     <= S_CRC_LO;
            end else begin
              state_q <= S_FETCH;
            end
          end else if (cmd_q == CMD_STAT && !beyond) begin
            is_stat_q <= 1'b1;
            state_q   <= S_FETCH;
          end else begin
            out_data_q  <= 8'hFF;
            out_valid_q <= 1'b1;
            state_q     <= S_ONES;
          end
        end
        S_FETCH: begin
          ff_q    <= is_stat_q && in_gap;
          state_q <= S_WAIT;
        end
        S_WAIT: begin
          out_data_q  <= fetched;
          out_valid_q <= 1'b1;
          state_q     <= S_SEND;
        end
        S_SEND: begin
          if (take_out) begin
            if (seg_end) begin
              out_data_q <= ~crc_q[7:0];
              state_q    <= S_CRC_LO;
            end else begin
              out_valid_q <= 1'b0;
              addr_q      <= addr_q + 16'd1;
              state_q     <= S_FETCH;
            end
          end
        end
        S_CRC_LO: begin
          if (take_out) begin
            out_data_q <= ~crc_q[15:8];
            state_q    <= S_CRC_HI;
          end
        end
        S_CRC_HI: begin
          if (take_out) begin
            if (is_stat_q && !last_end) begin
              out_valid_q <= 1'b0;
              addr_q      <= addr_q + 16'd1;
              state_q     <= S_FETCH;
            end else begin
              out_data_q <= 8'hFF;
              state_q    <= S_ONES;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign out_valid    = out_valid_q;
  assign out_data     = out_data_q;
  assign mem_rd_en    = (state_q == S_FETCH) && !(is_stat_q && in_gap);
  assign mem_rd_field = is_stat_q;
  assign mem_rd_addr  = addr_q;

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst || abort_i)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_abort_R5: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> (!out_valid && in_ready));

  assert_excl_R1: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !out_valid);

  assert_no_gap_read_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && mem_rd_field) |-> !((mem_rd_addr >= GAP_LO) && (mem_rd_addr <= GAP_HI)));

  assert_main_range_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && !mem_rd_field) |-> ((mem_rd_addr >> MAIN_AW) == '0));

  assert_stat_range_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && mem_rd_field) |-> (mem_rd_addr <= STAT_LAST));

endmodule

// File: tb/test_memread_crc_seq.sv
`timescale 1ns/1ps
module test_memread_crc_seq;

  localparam int MAW = 5;
  localparam int MSZ = 1 << MAW;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        abort_i = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_ready = 1'b0;
  logic        mem_rd_en;
  logic        mem_rd_field;
  logic [15:0] mem_rd_addr;
  logic [7:0]  mem_rd_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  memread_crc_seq #(.MAIN_AW(MAW)) i_memread_crc_seq (
    .clk(clk), .rst(rst), .abort_i(abort_i),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .mem_rd_en(mem_rd_en), .mem_rd_field(mem_rd_field),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data)
  );

  function automatic logic [7:0] main_val(input int a);
    return 8'(a * 29 + 3);
  endfunction
  function automatic logic [7:0] stat_val(input int a);
    return 8'((a & 255) ^ 8'hC3) + 8'((a >> 8) & 1);
  endfunction

  always_ff @(posedge clk) begin
    if (mem_rd_en)
      mem_rd_data <= mem_rd_field ? stat_val(int'(mem_rd_addr[8:0]))
                                  : main_val(int'(mem_rd_addr[MAW-1:0]));
  end

  function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int k = 0; k < 8; k++) begin
      if ((r[0] ^ b[k]) != 1'b0) r = (r >> 1) ^ 16'hA001;
      else r = r >> 1;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_hdr(input logic [7:0] cmd, input logic [15:0] a, inout logic [15:0] crc);
    send_byte(cmd);
    send_byte(a[7:0]);
    send_byte(a[15:8]);
    crc = crc_upd(crc_upd(crc_upd(16'h0, cmd), a[7:0]), a[15:8]);
  endtask

  task automatic get_byte(output logic [7:0] b);
    @(negedge clk);
    while (!out_valid) @(negedge clk);
    b = out_data;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic pulse_abort();
    @(negedge clk);
    abort_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0;
    check(!out_valid && in_ready, "R5 abort idle", {14'h0, out_valid, in_ready}, 16'h0001);
  endtask

  task automatic get_trailer(input logic [15:0] crc, input string tag);
    logic [7:0] b;
    get_byte(b);
    check(b == ~crc[7:0], tag, {8'h0, b}, {8'h0, ~crc[7:0]});
    get_byte(b);
    check(b == ~crc[15:8], tag, {8'h0, b}, {8'h0, ~crc[15:8]});
  endtask

  task automatic get_ones(input int n, input string tag);
    logic [7:0] b;
    for (int i = 0; i < n; i++) begin
      get_byte(b);
      check(b == 8'hFF, tag, {8'h0, b}, 16'h00FF);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(in_ready == 1'b1, "R1 in_ready after reset", {15'h0, in_ready}, 16'h1);
    check(out_valid == 1'b0, "R1 out_valid after reset", {15'h0, out_valid}, 16'h0);
  endtask

  task automatic t_main_full();
    logic [15:0] crc;
    logic [7:0]  b;
    send_hdr(8'hF0, 16'h0014, crc);
    check(!in_ready, "R1 in_ready low while streaming", {15'h0, in_ready}, 16'h0);
    for (int a = 20; a < MSZ; a++) begin
      get_byte(b);
      check(b == main_val(a), "R2 main data", {8'h0, b}, {8'h0, main_val(a)});
      crc = crc_upd(crc, b);
    end
    get_trailer(crc, "R3 main trailer");
    get_ones(3, "R4 ones after main trailer");
    pulse_abort();
  endtask

  task automatic t_main_abort_stall();
    logic [15:0] crc;
    logic [7:0]  b, held;
    send_hdr(8'hF0, 16'h0000, crc);
    get_byte(b);
    check(b == main_val(0), "R2 main data addr0", {8'h0, b}, {8'h0, main_val(0)});
    get_byte(b);
    @(negedge clk);
    while (!out_valid) @(negedge clk);
    held = out_data;
    repeat (4) @(negedge clk);
    check(out_valid && out_data == held, "R10 hold while stalled", {8'h0, out_data}, {8'h0, held});
    check(held == main_val(2), "R2 main data addr2", {8'h0, held}, {8'h0, main_val(2)});
    pulse_abort();
    repeat (5) @(negedge clk);
    check(!out_valid, "R5 no output after abort", {15'h0, out_valid}, 16'h0);
  endtask

  task automatic t_stat_pages();
    logic [15:0] crc;
    logic [7:0]  b;
    send_hdr(8'hAA, 16'h01F5, crc);
    for (int a = 16'h1F5; a <= 16'h1F7; a++) begin
      get_byte(b);
      check(b == stat_val(a), "R6 status data", {8'h0, b}, {8'h0, stat_val(a)});
      crc = crc_upd(crc, b);
    end
    get_trailer(crc, "R6 status first trailer");
    crc = 16'h0;
    for (int a = 16'h1F8; a <= 16'h1FF; a++) begin
      get_byte(b);
      check(b == stat_val(a), "R7 status next page data", {8'h0, b}, {8'h0, stat_val(a)});
      crc = crc_upd(crc, b);
    end
    get_trailer(crc, "R7 status page-only trailer");
    get_ones(2, "R4 ones after last status page");
    pulse_abort();
  endtask

  task automatic t_stat_gap();
    logic [15:0] crc;
    logic [7:0]  b;
    send_hdr(8'hAA, 16'h005E, crc);
    for (int a = 16'h5E; a <= 16'h5F; a++) begin
      get_byte(b);
      check(b == stat_val(a), "R6 status data before gap", {8'h0, b}, {8'h0, stat_val(a)});
      crc = crc_upd(crc, b);
    end
    get_trailer(crc, "R6 trailer before gap");
    crc = 16'h0;
    for (int a = 0; a < 8; a++) begin
      get_byte(b);
      check(b == 8'hFF, "R8 gap reads 0xFF", {8'h0, b}, 16'h00FF);
      crc = crc_upd(crc, b);
    end
    get_trailer(crc, "R8 gap page trailer");
    pulse_abort();
  endtask

  task automatic t_oob_and_unknown();
    logic [15:0] crc;
    send_hdr(8'hAA, 16'h0200, crc);
    get_ones(2, "R9 status start beyond end");
    pulse_abort();
    send_hdr(8'hF0, 16'h0100, crc);
    get_trailer(crc, "R9 main start beyond end header-only trailer");
    get_ones(1, "R9 ones after header-only trailer");
    pulse_abort();
    send_hdr(8'h33, 16'h0000, crc);
    get_ones(2, "R9 unknown command");
    pulse_abort();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_main_full();
    t_main_abort_stall();
    t_stat_pages();
    t_stat_gap();
    t_oob_and_unknown();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog (R1..R10 run) actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule